// File: doc/BRIEF.md
# Palette Color Map Loader

This block is the host-facing load port of a 256-entry color lookup table. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. Software first writes an entry number into an index register. It then streams color components into a data register. Each component fills the next slot of the current entry, and after blue the entry number advances by itself. A whole palette can therefore be loaded by one index write followed by a long run of data writes.

The register bus is byte-addressed and carries 32-bit data. Byte enables give the size of each access. A word write to the data register delivers four components in a single cycle, so one word may finish one entry and begin the next. On a separate port, an 8-bit pixel value returns the 24-bit color of that entry. A one-cycle change pulse tells the display side that the map was altered and a full redraw is due.

Top module: `palette_loader`

## Requirements
- R1: A write with any byte enable set to offset 0x0 loads the entry index from `bus_wdata[7:0]` and returns the component phase to red. It does not change any entry.
- R2: A write to offset 0x4 with exactly one byte enable bit set supplies one component, taken from the enabled byte lane. Components fill the current entry in the order red, green, blue.
- R3: Storing a blue component increments the entry index modulo 256 and returns the phase to red.
- R4: A write to offset 0x4 with `bus_be` = 4'b1111 supplies four components, bits 31:24 first and bits 7:0 last. Each component advances phase and index exactly as a byte write would, so one word can span two entries, including the wrap from entry 255 to entry 0.
- R5: A data-register write whose byte enables are neither one-hot nor all ones has no effect. The same holds for a write to any offset other than 0x0 or 0x4: no entry changes, the phase and index do not move, and no change pulse is raised.
- R6: `map_changed` is high for exactly the one cycle after each accepted data-register write, and low otherwise.
- R7: `bus_rdata` reads as zero for both registers.
- R8: Reset sets every entry to zero, the index to 0 and the phase to red.
- R9: `pix_color` is {red, green, blue} of entry `pix_idx` and is combinational. A value written at a clock edge is visible on `pix_color` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; one-hot for a byte, all ones for a word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_color | output | 24 | Color of the looked-up entry, red in bits 23:16 |
| map_changed | output | 1 | One-cycle pulse after a color map write |

## Verification
The hardest state to reach is a word write that begins in the middle of an entry. The hardest case of that is one that spills across the index wrap from 255 to 0. A further hard case is an index write that cuts a partly filled entry short. None of these is visible directly, because the phase counter has no port. The stimulus therefore builds the phase up on purpose: it places byte writes before a word write, and it points the index at 255 before a word write. It then probes both affected entries through the lookup port.

// File: rtl/palette_loader.sv
module palette_loader #(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [23:0]       pix_color,
  output logic              map_changed
);
  localparam int N = 1 << IDX_W;

  logic [23:0]      pal [N];
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       ph_q;
  logic             chg_q;

  wire word_wr = (bus_be == 4'b1111);
  wire byte_wr = $onehot(bus_be);
  wire sel_idx = bus_wr && (bus_addr == ADDR_W'(IDX_OFS)) && (bus_be != 4'b0000);
  wire sel_dat = bus_wr && (bus_addr == ADDR_W'(DATA_OFS)) && (word_wr || byte_wr);

  logic [7:0]       lane_byte;
  logic [IDX_W-1:0] s_idx [5];
  logic [1:0]       s_ph  [5];
  logic [7:0]       s_byte[4];
  logic [3:0]       s_act;

  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < 4; i++)
      if (bus_be[i]) lane_byte = bus_wdata[8*i +: 8];
  end

  always_comb begin
    s_idx[0] = idx_q;
    s_ph[0]  = ph_q;
    for (int k = 0; k < 4; k++) begin
      s_act[k]  = sel_dat && (word_wr || k == 0);
      s_byte[k] = word_wr ? bus_wdata[8*(3-k) +: 8] : lane_byte;
      if (s_act[k] && s_ph[k] == 2'd2) begin
        s_idx[k+1] = s_idx[k] + 1'b1;
        s_ph[k+1]  = 2'd0;
      end else if (s_act[k]) begin
        s_idx[k+1] = s_idx[k];
        s_ph[k+1]  = s_ph[k] + 2'd1;
      end else begin
        s_idx[k+1] = s_idx[k];
        s_ph[k+1]  = s_ph[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) pal[e] <= '0;
      idx_q <= '0;
      ph_q  <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= sel_dat;
      if (sel_idx) begin
        idx_q <= bus_wdata[IDX_W-1:0];
        ph_q  <= '0;
      end else if (sel_dat) begin
        idx_q <= s_idx[4];
        ph_q  <= s_ph[4];
      end
      for (int k = 0; k < 4; k++) begin
        if (s_act[k]) begin
          case (s_ph[k])
            2'd0:    pal[s_idx[k]][23:16] <= s_byte[k];
            2'd1:    pal[s_idx[k]][15:8]  <= s_byte[k];
            2'd2:    pal[s_idx[k]][7:0]   <= s_byte[k];
            default: ;
          endcase
        end
      end
    end
  end

  assign pix_color   = pal[pix_idx];
  assign map_changed = chg_q;
  assign bus_rdata   = '0;
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int IDX_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [23:0]       pix_color,
  input logic              map_changed
);
  logic dat_acc, idx_acc;
  assign dat_acc = bus_wr && bus_addr == ADDR_W'(DATA_OFS) &&
                   (bus_be == 4'b1111 || $countones(bus_be) == 1);
  assign idx_acc = bus_wr && bus_addr == ADDR_W'(IDX_OFS);

  p_pulse_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_acc |=> map_changed);

  p_no_spurious_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_acc |=> !map_changed);

  p_lookup_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr ##1 $stable(pix_idx) |-> $stable(pix_color));

  p_index_write_keeps_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_acc ##1 $stable(pix_idx) |-> $stable(pix_color));

  p_ignored_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !dat_acc && !idx_acc) ##1 $stable(pix_idx) |-> $stable(pix_color));
endmodule

bind palette_loader palette_loader_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .pix_idx(pix_idx), .pix_color(pix_color),
  .map_changed(map_changed)
);

// File: tb/tb_palette_loader.sv
module tb_palette_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_color;
  logic        map_changed;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  palette_loader dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_color(pix_color), .map_changed(map_changed)
  );

  // {addr[3], be[4], wdata[32], probe[8], expected color[24]}
  localparam int NV = 13;
  localparam logic [70:0] VEC [NV] = '{
    {3'd0, 4'b0001, 32'h0000_0010, 8'h10, 24'h000000},  // R1 index load
    {3'd4, 4'b0001, 32'h0000_0011, 8'h10, 24'h110000},  // R2 red
    {3'd4, 4'b0001, 32'h0000_0022, 8'h10, 24'h112200},  // R2 green
    {3'd4, 4'b0001, 32'h0000_0033, 8'h10, 24'h112233},  // R2 blue
    {3'd4, 4'b0001, 32'h0000_0044, 8'h11, 24'h440000},  // R3 next entry
    {3'd4, 4'b1111, 32'h5566_7788, 8'h11, 24'h445566},  // R4 word spans
    {3'd2, 4'b1111, 32'hDEAD_BEEF, 8'h12, 24'h778800},  // R5 bad offset
    {3'd4, 4'b0001, 32'h0000_0099, 8'h12, 24'h778899},  // R2 phase kept
    {3'd0, 4'b1111, 32'h0000_00FF, 8'hFF, 24'h000000},  // R1 word index
    {3'd4, 4'b1111, 32'hA1B2_C3D4, 8'hFF, 24'hA1B2C3},  // R4 wrap
    {3'd4, 4'b0011, 32'hEEEE_EEEE, 8'h00, 24'hD40000},  // R5 bad enables
    {3'd4, 4'b0100, 32'h00E5_0000, 8'h00, 24'hD4E500},  // R2 lane 2
    {3'd0, 4'b0001, 32'h0000_0000, 8'h00, 24'hD4E500}   // R1 phase reset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic probe(input string req, input logic [7:0] i, input logic [23:0] exp);
    pix_idx = i;
    #1;
    chk(req, {8'h0, pix_color}, {8'h0, exp});
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    probe("R8", 8'h00, 24'h0);
    probe("R8", 8'h80, 24'h0);
    probe("R8", 8'hFF, 24'h0);
    chk("R6", {31'h0, map_changed}, 32'h0);
    chk("R7", bus_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] a;
      logic [3:0] be;
      logic       acc;
      a  = VEC[v][70:68];
      be = VEC[v][67:64];
      acc = (a == 3'd4) && (be == 4'b1111 || $countones(be) == 1);
      wr(a, be, VEC[v][63:32]);
      chk(acc ? "R6 pulse" : "R6 quiet", {31'h0, map_changed}, {31'h0, acc});
      chk("R7", bus_rdata, 32'h0);
      probe("R1-R5 vector", VEC[v][31:24], VEC[v][23:0]);
    end

    // R1: index write cut entry 0 short; next byte lands on red
    wr(3'd4, 4'b1000, 32'h0F00_0000);
    probe("R1", 8'h00, 24'h0FE500);
    // R4: word spanning entries leaves neighbour 0x11 and 0x12 intact
    probe("R4", 8'h11, 24'h445566);
    probe("R4", 8'h12, 24'h778899);
    // R6: pulse lasts one cycle
    @(negedge clk);
    chk("R6 one cycle", {31'h0, map_changed}, 32'h0);

    // R8: second reset clears entries and index
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    probe("R8", 8'h10, 24'h0);
    probe("R8", 8'hFF, 24'h0);
    wr(3'd4, 4'b0001, 32'h0000_005A);
    probe("R8 index 0", 8'h00, 24'h5A0000);
    // R9: lookup follows pix_idx combinationally
    probe("R9", 8'h01, 24'h0);
    probe("R9", 8'h00, 24'h5A0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule